// File: doc/BRIEF.md
# Two-Channel Millivolt Seven-Segment Readout

This block turns a 12-bit analog-to-digital converter into a four-digit voltmeter readout. A free-running sample timer starts one acquisition per sample period (100 ms by default). Each acquisition asks the converter for a result over a request/done/data handshake. A slide-switch input chooses which of the two analog inputs the converter samples. The returned code is scaled to whole millivolts over a 0 V to 5 V span. A sequential shift-and-add-3 unit turns the millivolt value into four decimal digits, and these drive four common-anode seven-segment digits as `V.mmm`.

A four-state machine sequences the work. `ST_IDLE` waits for the timer tick and moves to `ST_REQ`, latching the channel. `ST_REQ` holds the request until the converter reports done, captures the code and moves to `ST_LOAD`. `ST_LOAD` starts the decimal converter and moves to `ST_CONV`. `ST_CONV` waits for the converter's valid pulse, loads the display register and returns to `ST_IDLE`. Only that last transition changes the visible digits.

Top module: `mv_seg_display`

## Requirements
- R1: During and right after reset, `adc_req` is 0, `dp_n` is 4'b0111, and `seg_n` shows 0.000: every digit carries the active-low pattern for 0.
- R2: The first request rises `PERIOD` = `CLK_KHZ*SAMPLE_MS` clock cycles after reset is released. Later rising edges of `adc_req` are exactly `PERIOD` cycles apart, provided each acquisition ends within that period.
- R3: Once raised, `adc_req` stays high until a clock edge samples `adc_done` high. It is low in the cycle that follows that edge.
- R4: `adc_chan` takes the value of `chan_sel` at the edge where a request starts. It stays constant while `adc_req` is high, so a switch change during a request applies only from the next request.
- R5: The displayed value is floor(code × 5000 / 4096) millivolts, where code is the `adc_data` word sampled with `adc_done`. It ranges from 0 to 4998.
- R6: `seg_n[27:21]` is the leftmost digit (volts), followed by tenths, hundredths and thousandths down to `seg_n[6:0]`. Within each digit, bit 0 is segment a and bit 6 is segment g, active low. Digits 0 to 9 use the usual seven-segment shapes.
- R7: Only the leftmost decimal point is lit: `dp_n` is 4'b0111 at all times.
- R8: `seg_n` keeps its old value for 14 clock edges after the edge that samples `adc_done`. It shows the new value from the 15th edge on, with no partial digits in between.
- R9: An `adc_done` pulse while no request is outstanding leaves `adc_req`, the display and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_sel | input | 1 | Slide switch selecting the analog input |
| adc_req | output | 1 | Conversion request, held until done |
| adc_chan | output | 1 | Channel to convert, valid while `adc_req` is high |
| adc_done | input | 1 | Converter result valid, sampled while requesting |
| adc_data | input | 12 | Converter result code |
| seg_n | output | 28 | Four digits of segments a..g, active low, leftmost digit in the top bits |
| dp_n | output | 4 | Decimal points, active low, bit 3 leftmost |

## Verification
Counted from the edge that samples `adc_done`, the request drops one cycle later and the new digits appear 15 edges later. The bench therefore samples at the falling edge after the 14th edge, where it expects the old pattern, and after the 15th, where it expects the new one. Requests are timed by a posedge counter started at reset release, so each rise must land exactly on a multiple of `PERIOD`. Channel capture is checked both when the request rises and a few cycles later, after the switch has moved.

// File: rtl/mvd_pkg.sv
package mvd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_LOAD,
        ST_CONV
    } acq_state_t;

    localparam int SEG_W = 7;
    localparam int NIB_W = 4;

endpackage

// File: rtl/sample_timer.sv
module sample_timer #(
    parameter int PERIOD = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mv_scaler.sv
module mv_scaler #(
    parameter int ADC_W   = 12,
    parameter int FULL_MV = 5000,
    parameter int MV_W    = 13
) (
    input  logic [ADC_W-1:0] code,
    output logic [MV_W-1:0]  mv
);
    localparam int PROD_W = ADC_W + MV_W;

    logic [PROD_W-1:0] prod;

    // code * FULL_MV / 2**ADC_W, truncated
    assign prod = PROD_W'(code) * PROD_W'(FULL_MV);
    assign mv   = prod[ADC_W +: MV_W];

endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
    import mvd_pkg::*;
#(
    parameter int BIN_W  = 13,
    parameter int DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [BIN_W-1:0]        bin,
    output logic                    busy,
    output logic                    valid,
    output logic [NIB_W*DIGITS-1:0] bcd
);
    localparam int BCD_W = NIB_W * DIGITS;
    localparam int CNT_W = $clog2(BIN_W + 1);

    logic [BCD_W-1:0] bcd_q;
    logic [BCD_W-1:0] adj;
    logic [BIN_W-1:0] bin_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             valid_q;

    // add 3 to every digit of 5 or more before the shift
    for (genvar d = 0; d < DIGITS; d++) begin : g_adj
        assign adj[NIB_W*d +: NIB_W] = (bcd_q[NIB_W*d +: NIB_W] >= 4'd5)
                                     ? bcd_q[NIB_W*d +: NIB_W] + 4'd3
                                     : bcd_q[NIB_W*d +: NIB_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcd_q   <= '0;
            bin_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                bcd_q  <= '0;
                bin_q  <= bin;
                cnt_q  <= CNT_W'(BIN_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                {bcd_q, bin_q} <= {adj[BCD_W-2:0], bin_q, 1'b0};
                cnt_q          <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign busy  = busy_q;
    assign valid = valid_q;
    assign bcd   = bcd_q;

    for (genvar d = 0; d < DIGITS; d++) begin : g_chk
        // R6
        bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid |-> (bcd_q[NIB_W*d +: NIB_W] <= 4'd9));
    end

    // R8
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q);

endmodule

// File: rtl/seg_digit_enc.sv
module seg_digit_enc
    import mvd_pkg::*;
(
    input  logic [NIB_W-1:0] digit,
    output logic [SEG_W-1:0] seg_n
);
    logic [SEG_W-1:0] lit;   // active high, bit0 = a .. bit6 = g

    always_comb begin
        unique case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
    end

    assign seg_n = ~lit;

endmodule

// File: rtl/mv_seg_display.sv
module mv_seg_display
    import mvd_pkg::*;
#(
    parameter int CLK_KHZ   = 50000,
    parameter int SAMPLE_MS = 100,
    parameter int ADC_W     = 12,
    parameter int FULL_MV   = 5000,
    parameter int DIGITS    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chan_sel,
    output logic                    adc_req,
    output logic                    adc_chan,
    input  logic                    adc_done,
    input  logic [ADC_W-1:0]        adc_data,
    output logic [DIGITS*SEG_W-1:0] seg_n,
    output logic [DIGITS-1:0]       dp_n
);
    localparam int PERIOD = CLK_KHZ * SAMPLE_MS;
    localparam int MV_W   = $clog2(FULL_MV + 1);
    localparam int BCD_W  = NIB_W * DIGITS;

    acq_state_t       state_q, state_d;
    logic             tick;
    logic             chan_q;
    logic [ADC_W-1:0] code_q;
    logic [MV_W-1:0]  mv;
    logic             bcd_start;
    logic             bcd_busy;
    logic             bcd_valid;
    logic [BCD_W-1:0] bcd;
    logic [BCD_W-1:0] disp_q;
    logic             disp_load;

    sample_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mv_scaler #(.ADC_W(ADC_W), .FULL_MV(FULL_MV), .MV_W(MV_W)) u_scale (
        .code (code_q),
        .mv   (mv)
    );

    bin2bcd_seq #(.BIN_W(MV_W), .DIGITS(DIGITS)) u_bcd (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bcd_start),
        .bin   (mv),
        .busy  (bcd_busy),
        .valid (bcd_valid),
        .bcd   (bcd)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (tick)      state_d = ST_REQ;
            ST_REQ:  if (adc_done)  state_d = ST_LOAD;
            ST_LOAD:                state_d = ST_CONV;
            ST_CONV: if (bcd_valid) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        adc_req   = 1'b0;
        bcd_start = 1'b0;
        disp_load = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  adc_req   = 1'b1;
            ST_LOAD: bcd_start = 1'b1;
            ST_CONV: disp_load = bcd_valid;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= 1'b0;
            code_q <= '0;
            disp_q <= '0;
        end else begin
            if (state_q == ST_IDLE && tick)    chan_q <= chan_sel;
            if (state_q == ST_REQ && adc_done) code_q <= adc_data;
            if (disp_load)                     disp_q <= bcd;
        end
    end

    assign adc_chan = chan_q;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        seg_digit_enc u_enc (
            .digit (disp_q[NIB_W*d +: NIB_W]),
            .seg_n (seg_n[SEG_W*d +: SEG_W])
        );
        assign dp_n[d] = (d == DIGITS - 1) ? 1'b0 : 1'b1;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_done) |=> adc_req);

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && adc_done) |=> !adc_req);

    // R2
    req_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_req ##1 adc_req) |-> $past(tick));

    // R4
    chan_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req ##1 adc_req) |-> $stable(adc_chan));

    // R8
    disp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bcd_valid |=> $stable(seg_n));

    // R9
    done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tick && adc_done) |=> (!adc_req && $stable(seg_n)));

    // R8
    busy_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !bcd_busy);

endmodule

// File: tb/sim_mv_seg_display.sv
`timescale 1ns/1ps
module sim_mv_seg_display;

    localparam int PERIOD = 64;
    localparam int NVEC   = 9;

    // {adc code, expected millivolts}
    localparam logic [24:0] VEC [NVEC] = '{
        {12'd2048, 13'd2500},
        {12'd0,    13'd0},
        {12'd1,    13'd1},
        {12'd819,  13'd999},
        {12'd820,  13'd1000},
        {12'd4095, 13'd4998},
        {12'd1234, 13'd1506},
        {12'd3000, 13'd3662},
        {12'd4094, 13'd4997}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_sel = 1'b0;
    logic        adc_req;
    logic        adc_chan;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic [27:0] seg_n;
    logic [3:0]  dp_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_req = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    mv_seg_display #(.CLK_KHZ(1), .SAMPLE_MS(PERIOD)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_sel (chan_sel),
        .adc_req  (adc_req),
        .adc_chan (adc_chan),
        .adc_done (adc_done),
        .adc_data (adc_data),
        .seg_n    (seg_n),
        .dp_n     (dp_n)
    );

    function automatic logic [6:0] seg_of(input int d);
        logic [6:0] on;
        case (d)
            0: on = 7'b0111111;
            1: on = 7'b0000110;
            2: on = 7'b1011011;
            3: on = 7'b1001111;
            4: on = 7'b1100110;
            5: on = 7'b1101101;
            6: on = 7'b1111101;
            7: on = 7'b0000111;
            8: on = 7'b1111111;
            default: on = 7'b1101111;
        endcase
        return ~on;
    endfunction

    function automatic logic [27:0] exp_seg(input int mv);
        return {seg_of((mv / 1000) % 10), seg_of((mv / 100) % 10),
                seg_of((mv / 10) % 10), seg_of(mv % 10)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_request(input logic exp_chan, input int gap);
        while (!adc_req) @(negedge clk);
        check("R2 request spacing", 32'(cyc - last_req), 32'(gap));
        last_req = cyc;
        check("R4 channel at request", 32'(adc_chan), 32'(exp_chan));
    endtask

    task automatic sample(input logic [11:0] code, input int mv, input logic exp_chan, input bit flip);
        logic [27:0] old;
        wait_request(exp_chan, PERIOD);
        if (flip) chan_sel = ~chan_sel;
        repeat (3) @(negedge clk);
        check("R3 request held", 32'(adc_req), 32'd1);
        check("R4 channel held", 32'(adc_chan), 32'(exp_chan));
        old = seg_n;
        adc_data = code;
        adc_done = 1'b1;
        @(negedge clk);            // edge E0 has sampled done
        adc_done = 1'b0;
        adc_data = 12'hABC;
        check("R3 request dropped", 32'(adc_req), 32'd0);
        repeat (14) @(negedge clk); // edges E1..E14
        check("R8 no partial update", 32'(seg_n), 32'(old));
        @(negedge clk);            // edge E15
        check("R5 R6 displayed value", 32'(seg_n), 32'(exp_seg(mv)));
        check("R7 decimal point", 32'(dp_n), 32'b0111);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 req in reset", 32'(adc_req), 32'd0);
        check("R1 display in reset", 32'(seg_n), 32'(exp_seg(0)));
        check("R7 dp in reset", 32'(dp_n), 32'b0111);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", 32'(adc_req), 32'd0);
        last_req = 0;

        // table walk: alternate channels, one switch flip mid-request
        for (int i = 0; i < NVEC; i++) begin
            logic ch;
            ch = logic'(i % 2);
            chan_sel = ch;
            sample(VEC[i][24:13], int'(VEC[i][12:0]), ch, (i == 3));
        end

        // R9: stray done while idle
        @(negedge clk);
        adc_data = 12'd4095;
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 req after stray done", 32'(adc_req), 32'd0);
        check("R9 display after stray done", 32'(seg_n), 32'(exp_seg(3662 + 1335)));

        // normal acquisition still follows on schedule
        chan_sel = 1'b1;
        sample(12'd0, 0, 1'b1, 1'b0);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 display after second reset", 32'(seg_n), 32'(exp_seg(0)));
        check("R1 req after second reset", 32'(adc_req), 32'd0);
        rst_n = 1'b1;
        last_req = 0;
        chan_sel = 1'b0;
        sample(12'd2048, 2500, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule